// File: doc/BRIEF.md
# Fixed-Point Second-Order IIR Section

This block is a streaming second-order recursive filter section in direct form I. Each accepted input sample is combined with the two previous inputs and the two previous outputs through five programmable signed 32-bit fractional coefficients, and one output sample comes out per input. Several sections can be chained output-to-input to build higher-order filters.

The arithmetic shares a single 32x32 signed multiplier. One multiply-accumulate is done per cycle, over five cycles. The accumulator is 64 bits wide and is preloaded with a rounding word in its low half. The first feedback coefficient is supplied pre-negated at half scale, and the previous output is doubled before it is multiplied, so the product carries the full-scale term. The output is the accumulator high word doubled, clamped to the signed 32-bit range. Inputs and outputs use a valid/ready handshake. The coefficients and the rounding word are static configuration, changed only while the section is idle.

Top module: `biquad_section`

## Requirements
- R1: After reset, in_ready_o is 1, out_valid_o is 0, and all four history samples (two inputs, two outputs) are zero.
- R2: For each accepted sample, out_data_o equals sat(2*hi(acc)), where acc is the 64-bit two's-complement sum (wrapping) of {32'h0, round_i} + b0*x[n] + b1*x[n-1] + b2*x[n-2] + fb1*D + fb2*y[n-2]. All multiplies are signed 32x32. D is y[n-1] shifted left one bit and truncated to 32 bits.
- R3: The rounding word round_i enters the accumulator as an unsigned low word, with a zero high word. Different round_i values change the result exactly as the R2 formula gives.
- R4: If hi(acc) >= 2^30, the output is 32'h7FFFFFFF. If hi(acc) < -2^30, the output is 32'h80000000. In every other case the output is even.
- R5: An input is accepted on a clock edge where in_valid_i and in_ready_o are both 1. in_ready_o stays 0 for the next five edges, and out_valid_o is 1 from the sixth edge after acceptance.
- R6: While out_valid_o is 1 and out_ready_i is 0, out_data_o holds steady, out_valid_o stays 1, and no input is accepted.
- R7: The history shifts exactly once per output handshake. A sample held under backpressure is used once, and the following outputs still match R2.
- R8: With the coefficients b0=518315, b1=1036629, b2=518315, fb1=2099786147, fb2=-2054161904 and round_i=2^31, a constant input of 2^24 settles within 0.1% of 2^24 and stays there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| b0_i | input | 32 | Current-input coefficient, signed fraction |
| b1_i | input | 32 | Previous-input coefficient |
| b2_i | input | 32 | Second-previous-input coefficient |
| fb1_i | input | 32 | Minus half of the first feedback coefficient |
| fb2_i | input | 32 | Minus the second feedback coefficient |
| round_i | input | 32 | Accumulator low-word preload |
| in_valid_i | input | 1 | Input sample valid |
| in_ready_o | output | 1 | Section can accept a sample |
| in_data_i | input | 32 | Input sample, signed |
| out_valid_o | output | 1 | Output sample valid |
| out_ready_i | input | 1 | Downstream accepts output |
| out_data_o | output | 32 | Output sample, signed |

## Verification
The assertions check the handshake and timing rules on every cycle. These are the five-edge stall and sixth-edge output of R5, the held output under backpressure of R6, and the even-or-clamped output form of R4. The numeric result of each sample cannot be seen by a property. The bench scenarios compare every output against an integer model of the R2 arithmetic, drive the clamps in both directions, vary the rounding word, and run the long step response that shows settling without drift.

// File: rtl/biquad_pkg.sv
package biquad_pkg;
  localparam int unsigned NTAPS = 5;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MAC  = 2'd1,
    ST_OUT  = 2'd2
  } bq_state_e;
endpackage

// File: rtl/biquad_ctrl.sv
module biquad_ctrl
  import biquad_pkg::*;
#(
  parameter int unsigned SW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          in_valid_i,
  input  logic          out_ready_i,
  output logic          in_ready_o,
  output logic          out_valid_o,
  output logic          load_o,
  output logic          mac_en_o,
  output logic          shift_o,
  output logic [SW-1:0] step_o
);
  localparam logic [SW-1:0] LAST = SW'(NTAPS - 1);

  bq_state_e     state_q;
  logic [SW-1:0] step_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (in_valid_i) begin
          state_q <= ST_MAC;
          step_q  <= '0;
        end
        ST_MAC: begin
          if (step_q == LAST) state_q <= ST_OUT;
          else                step_q  <= step_q + 1'b1;
        end
        ST_OUT: if (out_ready_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign in_ready_o  = (state_q == ST_IDLE);
  assign out_valid_o = (state_q == ST_OUT);
  assign load_o      = in_ready_o && in_valid_i;
  assign mac_en_o    = (state_q == ST_MAC);
  assign shift_o     = out_valid_o && out_ready_i;
  assign step_o      = step_q;
endmodule

// File: rtl/biquad_mac.sv
module biquad_mac #(
  parameter int unsigned DW = 32,
  parameter int unsigned SW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          mac_en_i,
  input  logic [SW-1:0] step_i,
  input  logic [DW-1:0] b0_i,
  input  logic [DW-1:0] b1_i,
  input  logic [DW-1:0] b2_i,
  input  logic [DW-1:0] fb1_i,
  input  logic [DW-1:0] fb2_i,
  input  logic [DW-1:0] round_i,
  input  logic [DW-1:0] x0_i,
  input  logic [DW-1:0] x1_i,
  input  logic [DW-1:0] x2_i,
  input  logic [DW-1:0] y1_i,
  input  logic [DW-1:0] y2_i,
  output logic [DW-1:0] acc_hi_o
);
  localparam int unsigned AW = 2 * DW;

  logic [DW-1:0] op_c, op_d;
  logic [AW-1:0] prod, acc_q;

  // step order: three feed-forward taps, then the two feedback taps
  always_comb begin
    case (step_i)
      SW'(0):  begin op_c = b0_i;  op_d = x0_i; end
      SW'(1):  begin op_c = b1_i;  op_d = x1_i; end
      SW'(2):  begin op_c = b2_i;  op_d = x2_i; end
      SW'(3):  begin op_c = fb1_i; op_d = {y1_i[DW-2:0], 1'b0}; end
      default: begin op_c = fb2_i; op_d = y2_i; end
    endcase
  end

  assign prod = AW'($signed(op_c) * $signed(op_d));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       acc_q <= '0;
    else if (load_i)   acc_q <= {{DW{1'b0}}, round_i};
    else if (mac_en_i) acc_q <= acc_q + prod;
  end

  assign acc_hi_o = acc_q[AW-1:DW];
endmodule

// File: rtl/biquad_hist.sv
module biquad_hist #(
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          shift_i,
  input  logic [DW-1:0] in_data_i,
  input  logic [DW-1:0] acc_hi_i,
  output logic [DW-1:0] x0_o,
  output logic [DW-1:0] x1_o,
  output logic [DW-1:0] x2_o,
  output logic [DW-1:0] y1_o,
  output logic [DW-1:0] y2_o,
  output logic [DW-1:0] y_o
);
  localparam logic [DW-1:0] POS_MAX = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] NEG_MIN = {1'b1, {(DW-1){1'b0}}};

  logic [DW-1:0] x0_q, x1_q, x2_q, y1_q, y2_q;

  // doubling overflows when the two top bits of the high word differ
  always_comb begin
    if (acc_hi_i[DW-1] != acc_hi_i[DW-2])
      y_o = acc_hi_i[DW-1] ? NEG_MIN : POS_MAX;
    else
      y_o = {acc_hi_i[DW-2:0], 1'b0};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x0_q <= '0; x1_q <= '0; x2_q <= '0;
      y1_q <= '0; y2_q <= '0;
    end else begin
      if (load_i) x0_q <= in_data_i;
      if (shift_i) begin
        x1_q <= x0_q;
        x2_q <= x1_q;
        y1_q <= y_o;
        y2_q <= y1_q;
      end
    end
  end

  assign x0_o = x0_q;
  assign x1_o = x1_q;
  assign x2_o = x2_q;
  assign y1_o = y1_q;
  assign y2_o = y2_q;
endmodule

// File: rtl/biquad_section.sv
module biquad_section
  import biquad_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] b0_i,
  input  logic [DW-1:0] b1_i,
  input  logic [DW-1:0] b2_i,
  input  logic [DW-1:0] fb1_i,
  input  logic [DW-1:0] fb2_i,
  input  logic [DW-1:0] round_i,
  input  logic          in_valid_i,
  output logic          in_ready_o,
  input  logic [DW-1:0] in_data_i,
  output logic          out_valid_o,
  input  logic          out_ready_i,
  output logic [DW-1:0] out_data_o
);
  localparam int unsigned SW = $clog2(NTAPS);

  logic          load, mac_en, shift;
  logic [SW-1:0] step;
  logic [DW-1:0] acc_hi, x0, x1, x2, y1, y2;

  biquad_ctrl #(.SW(SW)) u_ctrl (
    .clk_i, .rst_ni, .in_valid_i, .out_ready_i,
    .in_ready_o, .out_valid_o,
    .load_o(load), .mac_en_o(mac_en), .shift_o(shift), .step_o(step)
  );

  biquad_mac #(.DW(DW), .SW(SW)) u_mac (
    .clk_i, .rst_ni, .load_i(load), .mac_en_i(mac_en), .step_i(step),
    .b0_i, .b1_i, .b2_i, .fb1_i, .fb2_i, .round_i,
    .x0_i(x0), .x1_i(x1), .x2_i(x2), .y1_i(y1), .y2_i(y2),
    .acc_hi_o(acc_hi)
  );

  biquad_hist #(.DW(DW)) u_hist (
    .clk_i, .rst_ni, .load_i(load), .shift_i(shift),
    .in_data_i, .acc_hi_i(acc_hi),
    .x0_o(x0), .x1_o(x1), .x2_o(x2), .y1_o(y1), .y2_o(y2),
    .y_o(out_data_o)
  );
endmodule

// File: rtl/biquad_section_chk.sv
module biquad_section_chk #(
  parameter int unsigned DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          in_valid_i,
  input logic          in_ready_o,
  input logic          out_valid_o,
  input logic          out_ready_i,
  input logic [DW-1:0] out_data_o
);
  localparam logic [DW-1:0] POS_MAX = {1'b0, {(DW-1){1'b1}}};

  logic fire;
  assign fire = in_valid_i && in_ready_o;

  p_stall_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(fire, 1) || $past(fire, 2) || $past(fire, 3) || $past(fire, 4) || $past(fire, 5))
      |-> !in_ready_o);

  p_no_early_out_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(fire, 5) |-> !out_valid_o);

  p_out_on_time_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(fire, 6) |-> out_valid_o);

  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o)));

  p_no_accept_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> !in_ready_o);

  p_even_or_clamp_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_data_o != POS_MAX) |-> !out_data_o[0]);
endmodule

bind biquad_section biquad_section_chk #(.DW(DW)) u_chk (
  .clk_i, .rst_ni, .in_valid_i, .in_ready_o,
  .out_valid_o, .out_ready_i, .out_data_o
);

// File: tb/tb_biquad_section.sv
module tb_biquad_section;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic signed [DW-1:0] b0, b1, b2, fb1, fb2;
  logic [DW-1:0] rnd;
  logic in_valid = 1'b0, out_ready = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic in_ready, out_valid;
  logic [DW-1:0] out_data;

  int n_cmp = 0, n_bad = 0;
  logic signed [DW-1:0] rx1, rx2, ry1, ry2;

  always #(CLK_PERIOD/2) clk = ~clk;

  biquad_section #(.DW(DW)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .b0_i(b0), .b1_i(b1), .b2_i(b2), .fb1_i(fb1), .fb2_i(fb2), .round_i(rnd),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_data_i(in_data),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_data_o(out_data)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] model(input logic signed [DW-1:0] x);
    longint acc, hi;
    logic signed [DW-1:0] d;
    logic [DW-1:0] y;
    d = ry1 <<< 1;
    acc = longint'(rnd);
    acc += longint'(b0) * longint'(x);
    acc += longint'(b1) * longint'(rx1);
    acc += longint'(b2) * longint'(rx2);
    acc += longint'(fb1) * longint'(d);
    acc += longint'(fb2) * longint'(ry2);
    hi = acc >>> 32;
    if (hi >= 64'sd1073741824)       y = 32'h7FFFFFFF;
    else if (hi < -64'sd1073741824)  y = 32'h80000000;
    else                             y = DW'(hi * 2);
    return y;
  endfunction

  function automatic void model_shift(input logic [DW-1:0] x, input logic [DW-1:0] y);
    rx2 = rx1; rx1 = x; ry2 = ry1; ry1 = y;
  endfunction

  task automatic model_clear();
    rx1 = '0; rx2 = '0; ry1 = '0; ry2 = '0;
  endtask

  // one sample through the section, with latency and model checks
  task automatic run_sample(input logic [DW-1:0] x, input string req, output logic [DW-1:0] y);
    logic [DW-1:0] exp;
    int lat;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_data = x;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    lat = 1;
    while (!out_valid && lat < 20) begin
      if (in_ready) check(1'b0, "R5 busy stall", 1, 0);
      @(negedge clk); lat++;
    end
    check(lat == 6, "R5 latency", lat, 6);
    y = out_data;
    exp = model(x);
    check(y == exp, req, longint'($signed(y)), longint'($signed(exp)));
    model_shift(x, exp);
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0; out_ready = 1'b0;
    model_clear();
    @(negedge clk);
    check(in_ready == 1'b1, "R1 ready after reset", in_ready, 1);
    check(out_valid == 1'b0, "R1 no valid after reset", out_valid, 0);
    rst_n = 1'b1;
  endtask

  task automatic set_bw();
    b0 = 32'sd518315; b1 = 32'sd1036629; b2 = 32'sd518315;
    fb1 = 32'sd2099786147; fb2 = -32'sd2054161904; rnd = 32'h80000000;
  endtask

  task automatic t_impulse();
    logic [DW-1:0] y;
    set_bw();
    do_reset();
    run_sample(32'h7FFFFFFF, "R2 impulse", y);
    for (int i = 0; i < 15; i++) run_sample('0, "R2 impulse tail", y);
  endtask

  task automatic t_reset_state();
    logic [DW-1:0] y;
    set_bw();
    do_reset();
    run_sample(32'h40000000, "R1 pre", y);
    run_sample(32'hC0000000, "R1 pre", y);
    do_reset();
    // zero history: first output from a zero input is exactly round-only
    run_sample('0, "R1 history cleared", y);
    check(y == 32'h0, "R1 zero out", longint'(y), 0);
  endtask

  task automatic t_mixed();
    logic [DW-1:0] y;
    b0 = 32'sh12345678; b1 = -32'sh0FEDCBA9; b2 = 32'sh07654321;
    fb1 = 32'sh3A000000; fb2 = -32'sh30000000; rnd = 32'h80000000;
    do_reset();
    for (int i = 0; i < 12; i++)
      run_sample(32'(i * 32'h1F3A5C71 + 32'h0BADF00D), "R2 mixed", y);
  endtask

  task automatic t_round();
    logic [DW-1:0] y;
    b0 = 32'sd3; b1 = 32'sd0; b2 = 32'sd0; fb1 = 32'sd0; fb2 = 32'sd0;
    // 3 * 0x55555555 = 0xFFFFFFFF: carry into high word only when round > 0
    rnd = 32'h0;
    do_reset();
    run_sample(32'h55555555, "R3 round zero", y);
    check(y == 32'h0, "R3 no carry", longint'(y), 0);
    rnd = 32'h00000001;
    do_reset();
    run_sample(32'h55555555, "R3 round one", y);
    check(y == 32'h2, "R3 carry", longint'(y), 2);
    rnd = 32'h80000000;
    fb1 = 32'sh40000000;
    for (int i = 0; i < 6; i++) run_sample(32'h55555555, "R3 round half", y);
  endtask

  task automatic t_sat();
    logic [DW-1:0] y;
    b0 = 32'sh80000000; b1 = 32'sh80000000; b2 = 32'sd0;
    fb1 = 32'sd0; fb2 = 32'sd0; rnd = 32'h80000000;
    do_reset();
    run_sample(32'h80000000, "R4 positive clamp", y);
    check(y == 32'h7FFFFFFF, "R4 positive clamp value", longint'(y), 32'h7FFFFFFF);
    do_reset();
    run_sample(32'h7FFFFFFF, "R4 near negative", y);
    check(y == 32'h80000002, "R4 unclamped even", longint'($signed(y)), -32'sd2147483646);
    run_sample(32'h7FFFFFFF, "R4 negative clamp", y);
    check(y == 32'h80000000, "R4 negative clamp value", longint'($signed(y)), -64'sd2147483648);
  endtask

  task automatic t_backpressure();
    logic [DW-1:0] y, held, exp;
    set_bw();
    do_reset();
    run_sample(32'h01000000, "R7 pre", y);
    @(negedge clk);
    in_valid = 1'b1; in_data = 32'h02000000;
    @(posedge clk);
    @(negedge clk);
    in_data = 32'h7FFFFFFF;
    for (int i = 0; i < 5; i++) @(negedge clk);
    exp = model(32'h02000000);
    held = out_data;
    check(out_valid == 1'b1, "R6 valid", out_valid, 1);
    check(held == exp, "R6 data", longint'(held), longint'(exp));
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      check(out_valid && in_ready == 1'b0 && out_data == held, "R6 hold",
            longint'(out_data), longint'(held));
    end
    in_valid = 1'b0;
    model_shift(32'h02000000, exp);
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    out_ready = 1'b0;
    check(in_ready == 1'b1 && out_valid == 1'b0, "R6 released", in_ready, 1);
    for (int i = 0; i < 4; i++) run_sample(32'h01000000, "R7 after hold", y);
  endtask

  task automatic t_step();
    logic [DW-1:0] y;
    int bad = 0;
    longint dev, worst = 0;
    set_bw();
    do_reset();
    for (int i = 0; i < 1200; i++) begin
      run_sample(32'h01000000, "R8 step model", y);
      if (i >= 1100) begin
        dev = longint'($signed(y)) - 64'sd16777216;
        if (dev < 0) dev = -dev;
        if (dev > worst) worst = dev;
        if (dev > 64'sd16777) bad++;
      end
    end
    check(bad == 0, "R8 settled within 0.1%", worst, 16777);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    set_bw();
    model_clear();
    repeat (2) @(negedge clk);
    check(in_ready == 1'b1 && out_valid == 1'b0, "R1 in reset", in_ready, 1);
    rst_n = 1'b1;
    t_reset_state();
    t_impulse();
    t_mixed();
    t_round();
    t_sat();
    t_backpressure();
    t_step();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule